// File: doc/BRIEF.md
# Flash deep power-down controller

This block manages the power state of a serial flash device. It watches the serial command stream (chip select, serial clock and serial input, all already synchronous to the system clock) and keeps a four-state power machine: `PS_STANDBY`, `PS_ENTER` (the timed interval into deep power-down), `PS_DEEP` and `PS_EXIT` (the timed interval back to standby). All decisions are taken at the cycle where chip select rises, using the first byte shifted in (the opcode) and the number of serial clock rising edges seen in that frame.

The power-down opcode 0xB9, sent on its own as exactly eight bits, takes `PS_STANDBY` to `PS_ENTER`. After `T_DP` cycles the machine moves on to `PS_DEEP`. In `PS_DEEP` only the wake/signature opcode 0xAB counts. If chip select rises exactly after its eighth bit, the machine goes to `PS_EXIT`, and after `T_RES` cycles it returns to `PS_STANDBY`. Sending 0xAB in standby leaves the state unchanged at once. Any other opcode in standby with at least eight bits is passed on as a one-cycle command strobe. In every other state, all commands are dropped. While 0xAB is being clocked past its opcode byte, in standby or deep power-down, an 8-bit signature is driven on the serial output, most significant bit first, repeating every eight clocks.

The transitions are named as follows. `DP_REQ` takes `PS_STANDBY` to `PS_ENTER`. `DP_DONE` takes `PS_ENTER` to `PS_DEEP`. `WAKE_REQ` takes `PS_DEEP` to `PS_EXIT`. `WAKE_DONE` takes `PS_EXIT` to `PS_STANDBY`. Every other frame leaves the state as it is.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: After reset, `pwr_state` is 0 (`PS_STANDBY`), `so_oe` is 0 and `cmd_fire` is 0. The state encoding is standby=0, enter=1, deep=2, exit=3.
- R2: In standby, a frame with opcode 0xB9 and exactly 8 clock bits sets `pwr_state` to 1 from the cycle after chip select rises. The state then holds for exactly `T_DP` cycles and then becomes 2. Opcode 0xB9 with any other bit count leaves the state at 0.
- R3: In deep power-down, a frame with opcode 0xAB and exactly 8 bits sets `pwr_state` to 3 for exactly `T_RES` cycles, after which it becomes 0. Opcode 0xAB with any other bit count leaves the state at 2.
- R4: In deep power-down, every opcode other than 0xAB leaves the state at 2 and produces no `cmd_fire`.
- R5: In standby, a frame whose opcode is neither 0xB9 nor 0xAB and that has 8 or more bits raises `cmd_fire` for exactly one cycle, the cycle after chip select rises, with `cmd_op` equal to the opcode. A frame with fewer than 8 bits raises nothing.
- R6: In standby, opcode 0xAB with exactly 8 bits leaves the state at 0 with no delay and raises no `cmd_fire`.
- R7: During states 1 and 3, every frame is ignored. The interval length and the target state are unchanged, `cmd_fire` stays 0 and `so_oe` stays 0.
- R8: When opcode 0xAB has been received in state 0 or 2 and chip select is still low, `so_oe` is 1 from the 8th rising edge onward. Before serial rising edge number 9+8k+j, `so` equals bit 7-j of `SIG`. In every other case `so_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| sck | input | 1 | Serial clock, sampled by clk, data taken on its rising edge |
| si | input | 1 | Serial data in, opcode MSB first |
| so | output | 1 | Serial data out carrying the signature |
| so_oe | output | 1 | Drive enable for `so` |
| cmd_fire | output | 1 | One-cycle strobe for a command allowed to execute |
| cmd_op | output | 8 | Opcode belonging to `cmd_fire` |
| pwr_state | output | 2 | Current power state (0 standby, 1 enter, 2 deep, 3 exit) |

## Verification
The hardest condition to reach is a frame that arrives while a timed interval is still running. The bench sends the power-down or wake opcode and then, with no idle gap, starts another frame that finishes before the interval ends. It checks that the interval still lasts its full length and lands in the expected state. Bit counts of 7, 8, 9 and 16 around each opcode test the exact byte boundary rule. Randomly mixed frames, drawn from a fixed seed, cover the standby and deep states against a bench model.

// File: rtl/flash_pwr_pkg.sv
package flash_pwr_pkg;

    typedef enum logic [1:0] {
        PS_STANDBY = 2'd0,
        PS_ENTER   = 2'd1,
        PS_DEEP    = 2'd2,
        PS_EXIT    = 2'd3
    } pwr_state_e;

    localparam logic [7:0] OP_DEEP = 8'hB9;
    localparam logic [7:0] OP_WAKE = 8'hAB;
    localparam int         OP_BITS = 8;

endpackage

// File: rtl/fpm_frame_rx.sv
module fpm_frame_rx #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic             si,
    output logic             frame_end,
    output logic             sck_rise,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [7:0]       opcode
);
    import flash_pwr_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] BYTE_LEN = CNT_W'(OP_BITS);

    logic cs_q;
    logic sck_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
        end
    end

    // chip select rising: frame closes while counter still holds its count
    assign frame_end = cs_n & ~cs_q;
    assign sck_rise  = sck & ~sck_q & ~cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            opcode  <= '0;
        end else if (cs_q) begin
            bit_cnt <= '0;
            opcode  <= '0;
        end else if (sck_rise) begin
            if (bit_cnt < BYTE_LEN) begin
                opcode <= {opcode[6:0], si};
            end
            if (bit_cnt != CNT_MAX) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpm_delay_timer.sv
module fpm_delay_timer #(
    parameter int TW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign done = (remain == '0);

endmodule

// File: rtl/fpm_sig_shift.sv
module fpm_sig_shift #(
    parameter logic [7:0] SIG   = 8'h5C,
    parameter int         CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck_rise,
    input  logic [CNT_W-1:0] bit_cnt,
    output logic             sig_bit
);
    import flash_pwr_pkg::*;

    localparam logic [CNT_W-1:0] BYTE_LEN = CNT_W'(OP_BITS);

    logic [2:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (cs_n) begin
            idx <= '0;
        end else if (sck_rise && (bit_cnt >= BYTE_LEN)) begin
            idx <= idx + 3'd1;
        end
    end

    assign sig_bit = SIG[3'd7 - idx];

endmodule

// File: rtl/fpm_pwr_fsm.sv
module fpm_pwr_fsm #(
    parameter int T_DP  = 48,
    parameter int T_RES = 64,
    parameter int CNT_W = 6,
    parameter int TW    = 7
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_end,
    input  logic [CNT_W-1:0]          bit_cnt,
    input  logic [7:0]                opcode,
    input  logic                      tmr_done,
    output flash_pwr_pkg::pwr_state_e state,
    output logic                      tmr_load,
    output logic [TW-1:0]             tmr_val,
    output logic                      cmd_fire,
    output logic [7:0]                cmd_op
);
    import flash_pwr_pkg::*;

    localparam logic [CNT_W-1:0] BYTE_LEN = CNT_W'(OP_BITS);
    localparam logic [TW-1:0]    DP_LOAD  = TW'(T_DP - 1);
    localparam logic [TW-1:0]    RES_LOAD = TW'(T_RES - 1);

    pwr_state_e nxt;
    logic       byte_exact;
    logic       byte_full;
    logic       pwr_op;

    assign byte_exact = (bit_cnt == BYTE_LEN);
    assign byte_full  = (bit_cnt >= BYTE_LEN);
    assign pwr_op     = (opcode == OP_DEEP) || (opcode == OP_WAKE);

    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            PS_STANDBY: begin
                if (frame_end && byte_exact && (opcode == OP_DEEP)) begin
                    nxt      = PS_ENTER;      // DP_REQ
                    tmr_load = 1'b1;
                    tmr_val  = DP_LOAD;
                end
            end
            PS_ENTER: begin
                if (tmr_done) begin
                    nxt = PS_DEEP;            // DP_DONE
                end
            end
            PS_DEEP: begin
                if (frame_end && byte_exact && (opcode == OP_WAKE)) begin
                    nxt      = PS_EXIT;       // WAKE_REQ
                    tmr_load = 1'b1;
                    tmr_val  = RES_LOAD;
                end
            end
            PS_EXIT: begin
                if (tmr_done) begin
                    nxt = PS_STANDBY;         // WAKE_DONE
                end
            end
            default: nxt = PS_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PS_STANDBY;
        end else begin
            state <= nxt;
        end
    end

    // outputs: command gating strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_fire <= 1'b0;
            cmd_op   <= '0;
        end else begin
            cmd_fire <= frame_end && byte_full && !pwr_op && (state == PS_STANDBY);
            if (frame_end && byte_full && !pwr_op && (state == PS_STANDBY)) begin
                cmd_op <= opcode;
            end
        end
    end

endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl #(
    parameter int         T_DP  = 48,
    parameter int         T_RES = 64,
    parameter logic [7:0] SIG   = 8'h5C,
    parameter int         CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sck,
    input  logic       si,
    output logic       so,
    output logic       so_oe,
    output logic       cmd_fire,
    output logic [7:0] cmd_op,
    output logic [1:0] pwr_state
);
    import flash_pwr_pkg::*;

    localparam int TMAX = (T_DP > T_RES) ? T_DP : T_RES;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [CNT_W-1:0] BYTE_LEN = CNT_W'(OP_BITS);

    logic             frame_end;
    logic             sck_rise;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       opcode;
    logic             tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             tmr_done;
    logic             sig_bit;
    logic             sig_act;
    pwr_state_e       state;

    fpm_frame_rx #(.CNT_W(CNT_W)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sck       (sck),
        .si        (si),
        .frame_end (frame_end),
        .sck_rise  (sck_rise),
        .bit_cnt   (bit_cnt),
        .opcode    (opcode)
    );

    fpm_delay_timer #(.TW(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    fpm_sig_shift #(.SIG(SIG), .CNT_W(CNT_W)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .bit_cnt  (bit_cnt),
        .sig_bit  (sig_bit)
    );

    fpm_pwr_fsm #(.T_DP(T_DP), .T_RES(T_RES), .CNT_W(CNT_W), .TW(TW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .bit_cnt   (bit_cnt),
        .opcode    (opcode),
        .tmr_done  (tmr_done),
        .state     (state),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .cmd_fire  (cmd_fire),
        .cmd_op    (cmd_op)
    );

    // signature drive only in the settled states
    assign sig_act   = !cs_n && (opcode == OP_WAKE) && (bit_cnt >= BYTE_LEN)
                       && ((state == PS_STANDBY) || (state == PS_DEEP));
    assign so_oe     = sig_act;
    assign so        = sig_act ? sig_bit : 1'b0;
    assign pwr_state = state;

endmodule

// File: rtl/fpm_checker.sv
module fpm_checker #(
    parameter int T_DP  = 48,
    parameter int T_RES = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       so_oe,
    input logic       cmd_fire,
    input logic [1:0] pwr_state
);
    logic [1:0] prev;
    logic       pv;
    int         run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 2'd0;
            pv   <= 1'b0;
            run  <= 0;
        end else begin
            prev <= pwr_state;
            pv   <= 1'b1;
            run  <= (pwr_state == prev) ? run + 1 : 1;
        end
    end

    AST_ENTER_TO_DEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && prev == 2'd1 && pwr_state != 2'd1) |-> (pwr_state == 2'd2)); // R2
    AST_ENTER_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && prev == 2'd1 && pwr_state != 2'd1) |-> (run == T_DP)); // R2
    AST_DEEP_FROM_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && pwr_state == 2'd2 && prev != 2'd2) |-> (prev == 2'd1)); // R4
    AST_EXIT_TO_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && prev == 2'd3 && pwr_state != 2'd3) |-> (pwr_state == 2'd0 && run == T_RES)); // R3
    AST_FIRE_IN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |-> (pv && prev == 2'd0)); // R7
    AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |=> !cmd_fire); // R5
    AST_SO_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        so_oe |-> (pwr_state == 2'd0 || pwr_state == 2'd2)); // R8

endmodule

bind flash_pwr_ctrl fpm_checker #(.T_DP(T_DP), .T_RES(T_RES)) u_fpm_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .so_oe     (so_oe),
    .cmd_fire  (cmd_fire),
    .pwr_state (pwr_state)
);

// File: tb/test_flash_pwr_ctrl.sv
module test_flash_pwr_ctrl;
    localparam int         T_DP  = 48;
    localparam int         T_RES = 64;
    localparam logic [7:0] SIG   = 8'h5C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sck = 1'b0;
    logic       si = 1'b0;
    logic       so;
    logic       so_oe;
    logic       cmd_fire;
    logic [7:0] cmd_op;
    logic [1:0] pwr_state;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int t0     = 0;
    int model  = 0;
    int unsigned seed_init;

    flash_pwr_ctrl #(.T_DP(T_DP), .T_RES(T_RES), .SIG(SIG)) i_flash_pwr_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .so(so), .so_oe(so_oe), .cmd_fire(cmd_fire), .cmd_op(cmd_op),
        .pwr_state(pwr_state)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // one frame; sig_exp says whether the signature must appear after bit 8
    task automatic frame(input logic [7:0] op, input int nb, input bit sig_exp);
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            sck = 1'b0;
            si  = (i < 8) ? op[7-i] : 1'($urandom_range(0, 1));
            @(negedge clk);
            if (i >= 8) begin
                if (sig_exp) begin
                    chk(so_oe === 1'b1, "R8 so_oe", int'(so_oe), 1);
                    chk(so === SIG[7-((i-8)%8)], "R8 so bit", int'(so), int'(SIG[7-((i-8)%8)]));
                end else begin
                    chk(so_oe === 1'b0, "R7 so_oe idle", int'(so_oe), 0);
                end
            end
            @(negedge clk) sck = 1'b1;
            @(negedge clk);
        end
        sck = 1'b0;
        @(negedge clk) cs_n = 1'b1;
        t0 = cyc;
    endtask

    // after a frame in a settled state: strobe and state outcome
    task automatic settle(input bit fire_exp, input logic [7:0] op, input int nxt, input string req);
        wait_until(t0 + 1);
        chk(cmd_fire === fire_exp, req, int'(cmd_fire), int'(fire_exp));
        if (fire_exp) chk(cmd_op === op, "R5 cmd_op", int'(cmd_op), int'(op));
        chk(so_oe === 1'b0, "R8 so_oe after cs high", int'(so_oe), 0);
        wait_until(t0 + 2);
        chk(cmd_fire === 1'b0, "R5 strobe width", int'(cmd_fire), 0);
        if (nxt == 1) begin
            chk(pwr_state === 2'd1, "R2 enter", int'(pwr_state), 1);
            wait_until(t0 + T_DP);
            chk(pwr_state === 2'd1, "R2 enter end", int'(pwr_state), 1);
            wait_until(t0 + T_DP + 1);
            chk(pwr_state === 2'd2, "R2 deep", int'(pwr_state), 2);
            model = 2;
        end else if (nxt == 3) begin
            chk(pwr_state === 2'd3, "R3 exit", int'(pwr_state), 3);
            wait_until(t0 + T_RES);
            chk(pwr_state === 2'd3, "R3 exit end", int'(pwr_state), 3);
            wait_until(t0 + T_RES + 1);
            chk(pwr_state === 2'd0, "R3 standby", int'(pwr_state), 0);
            model = 0;
        end else begin
            chk(pwr_state === 2'(nxt), req, int'(pwr_state), nxt);
        end
    endtask

    function automatic int next_of(input int s, input logic [7:0] op, input int nb);
        if (s == 0 && op == 8'hB9 && nb == 8) return 1;
        if (s == 2 && op == 8'hAB && nb == 8) return 3;
        return s;
    endfunction

    function automatic bit fire_of(input int s, input logic [7:0] op, input int nb);
        return (s == 0) && (nb >= 8) && (op != 8'hB9) && (op != 8'hAB);
    endfunction

    task automatic run_frame(input logic [7:0] op, input int nb, input string req);
        int  n;
        bit  f;
        n = next_of(model, op, nb);
        f = fire_of(model, op, nb);
        frame(op, nb, op == 8'hAB);
        settle(f, op, n, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seed_init = $urandom(32'h1F2E3D4C);
        repeat (3) @(negedge clk);
        chk(pwr_state === 2'd0, "R1 state", int'(pwr_state), 0);
        chk(so_oe === 1'b0, "R1 so_oe", int'(so_oe), 0);
        chk(cmd_fire === 1'b0, "R1 cmd_fire", int'(cmd_fire), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_frame(8'h03, 16, "R5 command fires");
        run_frame(8'h06, 7,  "R5 short frame dropped");
        run_frame(8'h9F, 8,  "R5 exact byte fires");
        run_frame(8'hAB, 8,  "R6 wake in standby");
        run_frame(8'hAB, 16, "R8 signature in standby");
        run_frame(8'hB9, 9,  "R2 long deep opcode dropped");
        run_frame(8'hB9, 7,  "R2 short deep opcode dropped");

        // R7: frame during enter interval
        frame(8'hB9, 8, 1'b0);
        begin
            int ts;
            ts = t0;
            frame(8'hAB, 10, 1'b0);
            wait_until(t0 + 1);
            chk(cmd_fire === 1'b0, "R7 no fire in enter", int'(cmd_fire), 0);
            wait_until(ts + T_DP);
            chk(pwr_state === 2'd1, "R7 enter length kept", int'(pwr_state), 1);
            wait_until(ts + T_DP + 1);
            chk(pwr_state === 2'd2, "R7 deep reached", int'(pwr_state), 2);
            model = 2;
        end
        repeat (2) @(negedge clk);

        run_frame(8'h02, 16, "R4 program ignored in deep");
        run_frame(8'hC7, 8,  "R4 erase ignored in deep");
        run_frame(8'hAB, 7,  "R3 short wake ignored");
        run_frame(8'hAB, 9,  "R3 long wake keeps deep");

        // R7: frame during exit interval
        frame(8'hAB, 8, 1'b1);
        begin
            int ts;
            ts = t0;
            frame(8'h06, 8, 1'b0);
            wait_until(t0 + 1);
            chk(cmd_fire === 1'b0, "R7 no fire in exit", int'(cmd_fire), 0);
            wait_until(ts + T_RES);
            chk(pwr_state === 2'd3, "R7 exit length kept", int'(pwr_state), 3);
            wait_until(ts + T_RES + 1);
            chk(pwr_state === 2'd0, "R7 standby reached", int'(pwr_state), 0);
            model = 0;
        end
        repeat (2) @(negedge clk);

        for (int k = 0; k < 40; k++) begin
            logic [7:0] op;
            int         nb;
            int         pick;
            pick = $urandom_range(0, 3);
            op = (pick == 0) ? 8'hB9 : (pick == 1) ? 8'hAB : 8'($urandom_range(0, 255));
            case ($urandom_range(0, 3))
                0: nb = 7;
                1: nb = 8;
                2: nb = 9;
                default: nb = 16;
            endcase
            run_frame(op, nb, "R5 random frame");
            repeat (2) @(negedge clk);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule